// File: doc/BRIEF.md
# System Control Coprocessor Register Bank

This block is the register bank of a small system-control coprocessor. The processor reaches it only through two register-transfer operations: a move into the coprocessor (write) and a move out of it (read). Each transfer carries a 32-bit instruction word. The block takes the register number from a field of that word and serves one of eight 32-bit registers. A second, narrow debug port reads and writes the same bank through a plain register number, with no instruction decoding.

Register 0 reads as a fixed identification word, 0x41440110. Writes to register 0 are still stored. Register 1 holds the live core configuration in its low byte. Its bits 7:4 drive four configuration outputs continuously. Every write to register 1, from either port, raises a one-cycle reconfigure strobe, so that the core notices the new mode at once. At reset, bits 7:4 of register 1 load from the core's configuration pins, so the outputs start out matching the pins.

Every request completes in exactly one cycle. Each port has its own two-state response machine. XS_IDLE moves to XS_RESP on a request, and XS_RESP either stays in XS_RESP on a back-to-back request or returns to XS_IDLE. The reconfigure strobe comes from a second machine. NS_STEADY moves to NS_NOTIFY on a register-1 write, and NS_NOTIFY either stays in NS_NOTIFY on a further register-1 write or returns to NS_STEADY.

Top module: `sysctl_cp_bank`

## Requirements
- R1: The transfer port selects a register with instruction bits [18:16]. Bit 19 and all other instruction bits are ignored, so a field value of 0xA in bits [19:16] addresses register 2.
- R2: A read of register 0 returns 0x41440110 on both ports, even after a different value has been written to register 0.
- R3: A write to any of registers 1 to 7 stores the full 32-bit value, and a later read of that register returns it on either port.
- R4: A request accepted at a clock edge drives done (cp_done_o or dbg_done_o) high for the cycle that follows, with read data valid in that same cycle. Done is low after any cycle without a request. A write response returns zero data.
- R5: Register 1 bits map to the outputs as follows: bit 4 drives prog32_o, bit 5 drives data32_o, bit 6 drives late_abort_o and bit 7 drives big_endian_o. The outputs take the new value in the cycle after the write. Bits 3:0 are stored but drive nothing.
- R6: While rst_n is low, register 1 becomes {24'h0, cfg_pins_i, 4'h0} and every other register becomes zero. Done and reconfigure are low after reset.
- R7: reconfig_o is high for exactly the cycle after each register-1 write from either port. Writes to other registers never raise it.
- R8: The debug port ignores writes to register numbers 8 to 15, so no register changes and no strobe is raised. A debug read of those numbers returns zero.
- R9: If both ports write the same register in the same cycle, the transfer-port value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_pins_i | input | 4 | Configuration pins loaded into register 1 bits 7:4 at reset |
| cp_valid_i | input | 1 | Transfer request |
| cp_write_i | input | 1 | 1 = move into coprocessor, 0 = move out |
| cp_instr_i | input | 32 | Instruction word carrying the register field |
| cp_wdata_i | input | 32 | Write data |
| cp_done_o | output | 1 | Transfer complete |
| cp_rdata_o | output | 32 | Transfer read data |
| dbg_valid_i | input | 1 | Debug request |
| dbg_write_i | input | 1 | Debug direction, 1 = write |
| dbg_idx_i | input | 4 | Debug register number |
| dbg_wdata_i | input | 32 | Debug write data |
| dbg_done_o | output | 1 | Debug access complete |
| dbg_rdata_o | output | 32 | Debug read data |
| prog32_o | output | 1 | Program space width select |
| data32_o | output | 1 | Data space width select |
| late_abort_o | output | 1 | Late abort timing select |
| big_endian_o | output | 1 | Byte order select |
| reconfig_o | output | 1 | One-cycle mode re-evaluation strobe |

## Verification
A corrupted stored word in registers 2 to 7 stays hidden until that register is read, and then shows on the read data one cycle after the request. A bad register 1 shows at once on the four configuration outputs, in the cycle after the faulty write or reset. A response machine stuck in the wrong state shows in the very next cycle as a missing or spurious done. A notify machine in the wrong state shows the same way, as a strobe that is absent, stretched or raised by a write to another register.

// File: rtl/sysctl_cp_pkg.sv
package sysctl_cp_pkg;

    localparam int unsigned CFG_W   = 4;
    localparam int unsigned CFG_LSB = 4;
    localparam logic [31:0] ID_WORD = 32'h4144_0110;

    typedef enum logic {
        XS_IDLE,
        XS_RESP
    } xfer_state_e;

    typedef enum logic {
        NS_STEADY,
        NS_NOTIFY
    } notify_state_e;

    typedef struct packed {
        logic big_endian;
        logic late_abort;
        logic data32;
        logic prog32;
    } core_cfg_t;

endpackage

// File: rtl/sysctl_cp_decode.sv
module sysctl_cp_decode #(
    parameter int unsigned NREG   = 8,
    parameter int unsigned IDX_LO = 16,
    parameter int unsigned DBG_IW = 4,
    localparam int unsigned IW    = $clog2(NREG)
) (
    input  logic [31:0]       instr,
    input  logic [DBG_IW-1:0] dbg_idx,
    output logic [IW-1:0]     cp_sel,
    output logic [IW-1:0]     dbg_sel,
    output logic              dbg_in_range
);

    logic unused_instr_bits;

    assign cp_sel            = instr[IDX_LO +: IW];
    assign unused_instr_bits = ^{instr[31:IDX_LO+IW], instr[IDX_LO-1:0]};
    assign dbg_sel           = dbg_idx[IW-1:0];
    assign dbg_in_range      = (dbg_idx < DBG_IW'(NREG));

endmodule

// File: rtl/sysctl_cp_regs.sv
module sysctl_cp_regs
    import sysctl_cp_pkg::*;
#(
    parameter int unsigned NREG     = 8,
    parameter int unsigned DW       = 32,
    parameter logic [DW-1:0] ID_VALUE = DW'(ID_WORD),
    localparam int unsigned IW      = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_pins,
    input  logic             a_we,
    input  logic [IW-1:0]    a_idx,
    input  logic [DW-1:0]    a_wd,
    input  logic             b_we,
    input  logic [IW-1:0]    b_idx,
    input  logic [DW-1:0]    b_wd,
    input  logic             b_in_range,
    output logic [DW-1:0]    a_rd,
    output logic [DW-1:0]    b_rd,
    output logic [DW-1:0]    cfg_word
);

    logic [NREG-1:0][DW-1:0] words;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] q;
        logic [DW-1:0] rst_val;

        assign rst_val = (g == 1) ? (DW'(cfg_pins) << CFG_LSB) : '0;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= rst_val;
            end else if (a_we && (a_idx == IW'(g))) begin
                q <= a_wd;
            end else if (b_we && (b_idx == IW'(g))) begin
                q <= b_wd;
            end
        end

        assign words[g] = q;
    end

    always_comb begin
        a_rd = (a_idx == '0) ? ID_VALUE : words[a_idx];
        if (!b_in_range) begin
            b_rd = '0;
        end else if (b_idx == '0) begin
            b_rd = ID_VALUE;
        end else begin
            b_rd = words[b_idx];
        end
    end

    assign cfg_word = words[1];

endmodule

// File: rtl/sysctl_cp_resp.sv
module sysctl_cp_resp
    import sysctl_cp_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [DW-1:0] rd_value,
    output logic          done,
    output logic [DW-1:0] rdata
);

    xfer_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE: if (req_valid) state_d = XS_RESP;
            XS_RESP: if (!req_valid) state_d = XS_IDLE;
            default: state_d = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (req_valid && !req_write) begin
            rdata <= rd_value;
        end else begin
            rdata <= '0;
        end
    end

    assign done = (state_q == XS_RESP);

endmodule

// File: rtl/sysctl_cp_notify.sv
module sysctl_cp_notify
    import sysctl_cp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_written,
    output logic strobe
);

    notify_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NS_STEADY: if (cfg_written) state_d = NS_NOTIFY;
            NS_NOTIFY: if (!cfg_written) state_d = NS_STEADY;
            default:   state_d = NS_STEADY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= NS_STEADY;
        end else begin
            state_q <= state_d;
        end
    end

    assign strobe = (state_q == NS_NOTIFY);

endmodule

// File: rtl/sysctl_cp_bank.sv
module sysctl_cp_bank
    import sysctl_cp_pkg::*;
#(
    parameter int unsigned NREG     = 8,
    parameter int unsigned DW       = 32,
    parameter int unsigned IDX_LO   = 16,
    parameter int unsigned DBG_IW   = 4,
    parameter logic [DW-1:0] ID_VALUE = DW'(ID_WORD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_pins_i,
    input  logic              cp_valid_i,
    input  logic              cp_write_i,
    input  logic [31:0]       cp_instr_i,
    input  logic [DW-1:0]     cp_wdata_i,
    output logic              cp_done_o,
    output logic [DW-1:0]     cp_rdata_o,
    input  logic              dbg_valid_i,
    input  logic              dbg_write_i,
    input  logic [DBG_IW-1:0] dbg_idx_i,
    input  logic [DW-1:0]     dbg_wdata_i,
    output logic              dbg_done_o,
    output logic [DW-1:0]     dbg_rdata_o,
    output logic              prog32_o,
    output logic              data32_o,
    output logic              late_abort_o,
    output logic              big_endian_o,
    output logic              reconfig_o
);

    localparam int unsigned IW = $clog2(NREG);

    logic [IW-1:0] cp_sel, dbg_sel;
    logic          dbg_in_range;
    logic          cp_we, dbg_we, cfg_written;
    logic [DW-1:0] cp_rd, dbg_rd, cfg_word;
    core_cfg_t     cfg;

    sysctl_cp_decode #(.NREG(NREG), .IDX_LO(IDX_LO), .DBG_IW(DBG_IW)) u_decode (
        .instr        (cp_instr_i),
        .dbg_idx      (dbg_idx_i),
        .cp_sel       (cp_sel),
        .dbg_sel      (dbg_sel),
        .dbg_in_range (dbg_in_range)
    );

    assign cp_we       = cp_valid_i && cp_write_i;
    assign dbg_we      = dbg_valid_i && dbg_write_i && dbg_in_range;
    assign cfg_written = (cp_we && (cp_sel == IW'(1))) || (dbg_we && (dbg_sel == IW'(1)));

    sysctl_cp_regs #(.NREG(NREG), .DW(DW), .ID_VALUE(ID_VALUE)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_pins   (cfg_pins_i),
        .a_we       (cp_we),
        .a_idx      (cp_sel),
        .a_wd       (cp_wdata_i),
        .b_we       (dbg_we),
        .b_idx      (dbg_sel),
        .b_wd       (dbg_wdata_i),
        .b_in_range (dbg_in_range),
        .a_rd       (cp_rd),
        .b_rd       (dbg_rd),
        .cfg_word   (cfg_word)
    );

    sysctl_cp_resp #(.DW(DW)) u_cp_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (cp_valid_i),
        .req_write (cp_write_i),
        .rd_value  (cp_rd),
        .done      (cp_done_o),
        .rdata     (cp_rdata_o)
    );

    sysctl_cp_resp #(.DW(DW)) u_dbg_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (dbg_valid_i),
        .req_write (dbg_write_i),
        .rd_value  (dbg_rd),
        .done      (dbg_done_o),
        .rdata     (dbg_rdata_o)
    );

    sysctl_cp_notify u_notify (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_written (cfg_written),
        .strobe      (reconfig_o)
    );

    assign cfg          = core_cfg_t'(cfg_word[CFG_LSB +: CFG_W]);
    assign prog32_o     = cfg.prog32;
    assign data32_o     = cfg.data32;
    assign late_abort_o = cfg.late_abort;
    assign big_endian_o = cfg.big_endian;

endmodule

// File: rtl/sysctl_cp_bank_chk.sv
module sysctl_cp_bank_chk #(
    parameter int unsigned NREG     = 8,
    parameter int unsigned DW       = 32,
    parameter int unsigned DBG_IW   = 4,
    parameter logic [DW-1:0] ID_VALUE = '0,
    localparam int unsigned IW      = $clog2(NREG)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cp_valid_i,
    input logic              cp_write_i,
    input logic [IW-1:0]     cp_field,
    input logic              cp_done_o,
    input logic [DW-1:0]     cp_rdata_o,
    input logic              dbg_valid_i,
    input logic              dbg_write_i,
    input logic [DBG_IW-1:0] dbg_idx_i,
    input logic              dbg_done_o,
    input logic [DW-1:0]     dbg_rdata_o,
    input logic              prog32_o,
    input logic              data32_o,
    input logic              late_abort_o,
    input logic              big_endian_o,
    input logic              reconfig_o
);

    logic wr_cfg;
    assign wr_cfg = (cp_valid_i && cp_write_i && (cp_field == IW'(1))) ||
                    (dbg_valid_i && dbg_write_i && (dbg_idx_i == DBG_IW'(1)));

    // R4
    cp_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cp_valid_i |=> cp_done_o);

    // R4
    cp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cp_valid_i |=> !cp_done_o);

    // R4
    dbg_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_valid_i |=> dbg_done_o);

    // R2
    id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_valid_i && !cp_write_i && cp_field == '0) |=> (cp_rdata_o == ID_VALUE));

    // R7
    strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cfg |=> reconfig_o);

    // R7
    no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cfg |=> !reconfig_o);

    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cfg |=> $stable({prog32_o, data32_o, late_abort_o, big_endian_o}));

    // R8
    dbg_oob_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_valid_i && !dbg_write_i && dbg_idx_i >= DBG_IW'(NREG)) |=> (dbg_rdata_o == '0));

endmodule

bind sysctl_cp_bank sysctl_cp_bank_chk #(
    .NREG(NREG), .DW(DW), .DBG_IW(DBG_IW), .ID_VALUE(ID_VALUE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cp_valid_i   (cp_valid_i),
    .cp_write_i   (cp_write_i),
    .cp_field     (cp_instr_i[IDX_LO +: $clog2(NREG)]),
    .cp_done_o    (cp_done_o),
    .cp_rdata_o   (cp_rdata_o),
    .dbg_valid_i  (dbg_valid_i),
    .dbg_write_i  (dbg_write_i),
    .dbg_idx_i    (dbg_idx_i),
    .dbg_done_o   (dbg_done_o),
    .dbg_rdata_o  (dbg_rdata_o),
    .prog32_o     (prog32_o),
    .data32_o     (data32_o),
    .late_abort_o (late_abort_o),
    .big_endian_o (big_endian_o),
    .reconfig_o   (reconfig_o)
);

// File: tb/tb_sysctl_cp_bank.sv
`timescale 1ns/1ps
module tb_sysctl_cp_bank;

    localparam logic [31:0] ID   = 32'h4144_0110;
    localparam logic [31:0] BASE = 32'hEE00_0F10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_pins_i = 4'b1010;
    logic        cp_valid_i = 0, cp_write_i = 0;
    logic [31:0] cp_instr_i = '0, cp_wdata_i = '0;
    logic        cp_done_o;
    logic [31:0] cp_rdata_o;
    logic        dbg_valid_i = 0, dbg_write_i = 0;
    logic [3:0]  dbg_idx_i = '0;
    logic [31:0] dbg_wdata_i = '0;
    logic        dbg_done_o;
    logic [31:0] dbg_rdata_o;
    logic        prog32_o, data32_o, late_abort_o, big_endian_o, reconfig_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sysctl_cp_bank dut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ins(input logic [3:0] field);
        return BASE | ({28'h0, field} << 16);
    endfunction

    // one request on either or both ports, then idle; returns just after the response edge
    task automatic step(input logic cv, input logic cw, input logic [3:0] cf, input logic [31:0] cd,
                        input logic dv, input logic dw, input logic [3:0] di, input logic [31:0] dd);
        @(negedge clk);
        cp_valid_i = cv; cp_write_i = cw; cp_instr_i = ins(cf); cp_wdata_i = cd;
        dbg_valid_i = dv; dbg_write_i = dw; dbg_idx_i = di; dbg_wdata_i = dd;
        @(negedge clk);
        cp_valid_i = 0; cp_write_i = 0; dbg_valid_i = 0; dbg_write_i = 0;
    endtask

    task automatic cp_wr(input logic [3:0] f, input logic [31:0] d);
        step(1, 1, f, d, 0, 0, 0, 0);
    endtask

    task automatic cp_rd_chk(input logic [3:0] f, input logic [31:0] exp, input string req);
        step(1, 0, f, 0, 0, 0, 0, 0);
        chk(cp_done_o === 1'b1, {req, " done"}, {31'h0, cp_done_o}, 32'h1);
        chk(cp_rdata_o === exp, req, cp_rdata_o, exp);
    endtask

    task automatic dbg_rd_chk(input logic [3:0] i, input logic [31:0] exp, input string req);
        step(0, 0, 0, 0, 1, 0, i, 0);
        chk(dbg_done_o === 1'b1, {req, " dbg done"}, {31'h0, dbg_done_o}, 32'h1);
        chk(dbg_rdata_o === exp, req, dbg_rdata_o, exp);
    endtask

    function automatic logic [31:0] cfgv();
        return {28'h0, big_endian_o, late_abort_o, data32_o, prog32_o};
    endfunction

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(cp_done_o === 0 && dbg_done_o === 0, "R6 done low", {30'h0, cp_done_o, dbg_done_o}, 0);
        chk(reconfig_o === 0, "R6 strobe low", {31'h0, reconfig_o}, 0);
        chk(cfgv() === 32'hA, "R6 cfg from pins", cfgv(), 32'hA);
        cp_rd_chk(4'd1, 32'h0000_00A0, "R6 reg1 reset");
        cp_rd_chk(4'd3, 32'h0, "R6 reg3 reset");
    endtask

    task automatic t_id();
        cp_wr(4'd0, 32'hDEAD_BEEF);
        chk(cp_done_o === 1 && cp_rdata_o === 0, "R4 write response", cp_rdata_o, 0);
        cp_rd_chk(4'd0, ID, "R2 id via transfer");
        dbg_rd_chk(4'd0, ID, "R2 id via debug");
    endtask

    task automatic t_rw();
        for (int r = 2; r < 8; r++) cp_wr(4'(r), 32'h1111_0000 * r + 32'h5A);
        for (int r = 2; r < 8; r++) cp_rd_chk(4'(r), 32'h1111_0000 * r + 32'h5A, "R3 transfer readback");
        dbg_rd_chk(4'd6, 32'h6666_005A, "R3 debug readback");
        step(0, 0, 0, 0, 1, 1, 4'd4, 32'hCAFE_F00D);
        cp_rd_chk(4'd4, 32'hCAFE_F00D, "R3 debug write seen by transfer");
    endtask

    task automatic t_index();
        step(1, 1, 4'hA, 32'h0BAD_CAFE, 0, 0, 0, 0);
        cp_rd_chk(4'd2, 32'h0BAD_CAFE, "R1 bit19 ignored");
        cp_rd_chk(4'hF, 32'h7777_005A, "R1 field 0xF is reg7");
    endtask

    task automatic t_cfg();
        cp_wr(4'd1, 32'h0000_005F);
        chk(reconfig_o === 1, "R7 strobe after reg1 write", {31'h0, reconfig_o}, 1);
        chk(cfgv() === 32'h5, "R5 cfg bits 7:4=0101", cfgv(), 32'h5);
        @(negedge clk);
        chk(reconfig_o === 0, "R7 strobe one cycle", {31'h0, reconfig_o}, 0);
        cp_wr(4'd1, 32'h0000_0050);
        chk(cfgv() === 32'h5, "R5 bits 3:0 no function", cfgv(), 32'h5);
        cp_rd_chk(4'd1, 32'h0000_0050, "R5 reg1 stored");
        cp_wr(4'd3, 32'h0000_00F0);
        chk(reconfig_o === 0, "R7 no strobe for reg3", {31'h0, reconfig_o}, 0);
        chk(cfgv() === 32'h5, "R5 cfg held on reg3 write", cfgv(), 32'h5);
        step(0, 0, 0, 0, 1, 1, 4'd1, 32'h0000_0090);
        chk(reconfig_o === 1, "R7 strobe after debug reg1 write", {31'h0, reconfig_o}, 1);
        chk(cfgv() === 32'h9, "R5 cfg from debug write", cfgv(), 32'h9);
    endtask

    task automatic t_oob();
        step(0, 0, 0, 0, 1, 1, 4'd9, 32'h0000_0060);
        chk(dbg_done_o === 1, "R8 done on ignored write", {31'h0, dbg_done_o}, 1);
        chk(reconfig_o === 0, "R8 no strobe", {31'h0, reconfig_o}, 0);
        chk(cfgv() === 32'h9, "R8 cfg unchanged", cfgv(), 32'h9);
        cp_rd_chk(4'd1, 32'h0000_0090, "R8 reg1 unchanged");
        dbg_rd_chk(4'd9, 32'h0, "R8 oob read zero");
    endtask

    task automatic t_collide();
        step(1, 1, 4'd5, 32'hAAAA_0001, 1, 1, 4'd5, 32'hBBBB_0002);
        cp_rd_chk(4'd5, 32'hAAAA_0001, "R9 transfer wins");
    endtask

    task automatic t_b2b();
        @(negedge clk);
        cp_valid_i = 1; cp_write_i = 0; cp_instr_i = ins(4'd2);
        @(negedge clk);
        chk(cp_done_o === 1 && cp_rdata_o === 32'h0BAD_CAFE, "R4 b2b first", cp_rdata_o, 32'h0BAD_CAFE);
        cp_instr_i = ins(4'd0);
        @(negedge clk);
        chk(cp_done_o === 1 && cp_rdata_o === ID, "R4 b2b second", cp_rdata_o, ID);
        cp_valid_i = 0;
        @(negedge clk);
        chk(cp_done_o === 0, "R4 done drops", {31'h0, cp_done_o}, 0);
    endtask

    initial begin
        t_reset();
        t_id();
        t_rw();
        t_index();
        t_cfg();
        t_oob();
        t_collide();
        t_b2b();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule